// File: doc/BRIEF.md
# Prescaled Timebase Counter with Edge Capture

This block keeps an 8-bit timebase counter that software can never see or load. A prescaler divides the system clock by 32, or by 64 when the period-double bit is set. The counter runs from 0 to 249 and then wraps to 0. Each wrap sets a sticky tick flag, and that flag can raise an interrupt. At an 8 MHz clock the wrap interval is 1 ms, or 2 ms when the period is doubled.

An external capture pin passes through a two-flop synchronizer. A change in either direction then copies the current counter value into a read-only capture register and sets a capture flag. While that flag is set, further edges are ignored, so the register keeps the first accepted sample until software reads it.

A small register port reaches the block. Software writes the enable bits, reads the control/status register (which clears the tick flag) and reads the capture register (which clears the capture flag). Read data is registered.

Top module: `tick_capture_timer`

## Requirements
- R1: After reset the counter starts at 0. It advances by one on every prescaler tick, and one tick comes every 32 clocks while the period-double bit is 0. Its value never exceeds 249.
- R2: With the period-double bit at 0, the counter wraps from 249 to 0 on the 8000th clock edge after reset is released, and then every 8000 clocks.
- R3: Setting the period-double bit (control bit 2) makes the prescaler divide by 64. The interval between wraps is then 16000 clocks.
- R4: Each wrap sets the tick flag (status bit 0). `irq_tick` is high exactly when the tick flag and the tick enable (control bit 1) are both 1.
- R5: A read of address 0 returns the status as it stood before the read and clears the tick flag. If a wrap lands on the same edge as that read, the flag stays set.
- R6: The counter is not reachable from the bus. Reads of addresses 2 and 3 return 0. Writes to any address other than 0 change nothing.
- R7: A pin change in either direction is sampled at clock edge k. The capture register then receives the counter value as it stood after edge k+1, and the capture flag (status bit 3) is set after edge k+2.
- R8: `irq_capture` is high exactly when the capture flag and the capture enable (control bit 4) are both 1. A read of address 1 returns the capture register and clears the capture flag.
- R9: While the capture flag is set, pin edges neither change the capture register nor start a new capture.
- R10: Reset clears every register. Address 0 reads as {3'b0, capture enable, capture flag, period-double, tick enable, tick flag}. Writes to address 0 keep only bits 1, 2 and 4. `bus_rdata` updates on the edge that takes `bus_rd` and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| cap_pin | input | 1 | Asynchronous capture input |
| irq_tick | output | 1 | Tick interrupt request |
| irq_capture | output | 1 | Capture interrupt request |

## Verification
A counter wrap can fall on the same clock edge as the status read that clears the tick flag. The bench provokes this by issuing the read so that it is registered on clock 16000, which is the second wrap. It then expects two things: the read data shows the flag already cleared, and `irq_tick` stays high afterwards. A second read must then return the flag as set and clear it. Capture values are judged against a prescaler and counter model kept in the bench from the requirements. That model follows every change to the period-double bit.

// File: rtl/tcap_pkg.sv
// Package: shared register addresses and bit positions for the timebase/capture block.
// Assumes a 2-bit register address and 8-bit data.
package tcap_pkg;
    localparam int DATA_W = 8;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_CAPT = 2'd1;

    localparam int BIT_TICK_FLAG = 0;
    localparam int BIT_TICK_IE   = 1;
    localparam int BIT_SLOW      = 2;
    localparam int BIT_CAP_FLAG  = 3;
    localparam int BIT_CAP_IE    = 4;

    localparam logic [DATA_W-1:0] CTRL_WMASK =
        DATA_W'((1 << BIT_TICK_IE) | (1 << BIT_SLOW) | (1 << BIT_CAP_IE));
endpackage

// File: rtl/tcap_prescaler.sv
// Module: prescaler. Emits a one-cycle tick every 2**LOG2 clocks, or every
// 2**(LOG2+1) clocks when slow_sel is high. A select change mid-count takes effect
// on the running count; a count already past the new limit ends on the next cycle.
module tcap_prescaler #(
    parameter int LOG2 = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic slow_sel,
    output logic tick
);
    localparam int PW = LOG2 + 1;
    localparam logic [PW-1:0] LAST_FAST = PW'((1 << LOG2) - 1);
    localparam logic [PW-1:0] LAST_SLOW = {PW{1'b1}};

    logic [PW-1:0] div_q;
    logic [PW-1:0] last;

    // Pick the terminal count for the selected division.
    always_comb begin
        last = slow_sel ? LAST_SLOW : LAST_FAST;
        tick = (div_q >= last);
    end

    // Advance the divider, restarting after each tick.
    always_ff @(posedge clk) begin
        if (!rst_n)    div_q <= '0;
        else if (tick) div_q <= '0;
        else           div_q <= div_q + 1'b1;
    end

    p_tick_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/tcap_counter.sv
// Module: modulo timebase counter. Counts prescaler ticks from 0 to MAXV and then
// wraps to 0; wrap is high in the cycle whose edge performs the wrap.
module tcap_counter #(
    parameter int W    = 8,
    parameter int MAXV = 249
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    output logic [W-1:0] count,
    output logic         wrap
);
    localparam logic [W-1:0] TOP = W'(MAXV);

    logic [W-1:0] cnt_q;

    // Flag the edge on which the top value rolls over.
    always_comb begin
        wrap  = tick && (cnt_q == TOP);
        count = cnt_q;
    end

    // Step the count on each tick, wrapping at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (wrap) cnt_q <= '0;
        else if (tick) cnt_q <= cnt_q + 1'b1;
    end

    p_count_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= TOP);
    p_wrap_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> (cnt_q == '0));
endmodule

// File: rtl/tcap_capture.sv
// Module: edge capture. Synchronizes the pin through SYNC flops, detects either
// edge, and latches the counter into a hold register while the flag is clear.
// Assumes the pin may be fully asynchronous to clk.
module tcap_capture #(
    parameter int W    = 8,
    parameter int SYNC = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pin,
    input  logic [W-1:0] count,
    input  logic         clr,
    output logic [W-1:0] cap_val,
    output logic         cap_flag
);
    logic [SYNC:0]  sh_q;
    logic [W-1:0]   val_q;
    logic           flag_q;
    logic           edge_seen;
    logic           take;

    // Detect a level change between the last two synchronized samples.
    always_comb begin
        edge_seen = sh_q[SYNC] ^ sh_q[SYNC-1];
        take      = edge_seen && !flag_q;
        cap_val   = val_q;
        cap_flag  = flag_q;
    end

    // Synchronizer chain plus one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[SYNC-1:0], pin};
    end

    // Latch the counter on an accepted edge.
    always_ff @(posedge clk) begin
        if (!rst_n)    val_q <= '0;
        else if (take) val_q <= count;
    end

    // Capture flag: set by an accepted edge, cleared by a capture read.
    always_ff @(posedge clk) begin
        if (!rst_n)    flag_q <= 1'b0;
        else if (take) flag_q <= 1'b1;
        else if (clr)  flag_q <= 1'b0;
    end

    p_capture_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (flag_q && val_q == $past(count)));
    p_inhibit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr) |=> ($stable(val_q) && flag_q));
    p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && clr) |=> !flag_q);
endmodule

// File: rtl/tcap_regs.sv
// Module: register port. Holds the control bits and the tick flag, registers read
// data, and issues the clear-on-read strobe for the capture flag.
// Assumes single-cycle read and write strobes.
module tcap_regs
    import tcap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              wrap,
    input  logic [DATA_W-1:0] cap_val,
    input  logic              cap_flag,
    output logic              cap_clr,
    output logic              slow_sel,
    output logic              irq_tick,
    output logic              irq_capture
);
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] rdata_q;
    logic              tick_flag_q;
    logic              rd_ctrl;
    logic              wr_ctrl;
    logic [DATA_W-1:0] status;

    // Decode strobes and assemble the status view.
    always_comb begin
        rd_ctrl  = bus_rd && (bus_addr == ADDR_CTRL);
        wr_ctrl  = bus_wr && (bus_addr == ADDR_CTRL);
        cap_clr  = bus_rd && (bus_addr == ADDR_CAPT);
        status   = ctrl_q;
        status[BIT_TICK_FLAG] = tick_flag_q;
        status[BIT_CAP_FLAG]  = cap_flag;
        slow_sel    = ctrl_q[BIT_SLOW];
        irq_tick    = tick_flag_q && ctrl_q[BIT_TICK_IE];
        irq_capture = cap_flag && ctrl_q[BIT_CAP_IE];
        bus_rdata   = rdata_q;
    end

    // Control register: only the enable and select bits are stored.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= bus_wdata & CTRL_WMASK;
    end

    // Tick flag: a wrap wins over a clearing read on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n)       tick_flag_q <= 1'b0;
        else if (wrap)    tick_flag_q <= 1'b1;
        else if (rd_ctrl) tick_flag_q <= 1'b0;
    end

    // Registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n) rdata_q <= '0;
        else if (bus_rd) begin
            case (bus_addr)
                ADDR_CTRL: rdata_q <= status;
                ADDR_CAPT: rdata_q <= cap_val;
                default:   rdata_q <= '0;
            endcase
        end
    end

    p_tick_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> tick_flag_q);
    p_tick_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ctrl && !wrap) |=> !tick_flag_q);
    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(rdata_q));
    p_ctrl_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q & ~CTRL_WMASK) == '0);
endmodule

// File: rtl/tick_capture_timer.sv
// Module: top of the timebase/capture block. Wires the prescaler, the modulo-250
// counter, the capture unit and the register port. Assumes an 8-bit data bus.
module tick_capture_timer #(
    parameter int PRESC_LOG2 = 5,
    parameter int CNT_W      = 8,
    parameter int CNT_MAX    = 249,
    parameter int SYNC_DEPTH = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       cap_pin,
    output logic       irq_tick,
    output logic       irq_capture
);
    logic             slow_sel;
    logic             tick;
    logic             wrap;
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] cap_val;
    logic             cap_flag;
    logic             cap_clr;

    tcap_prescaler #(.LOG2(PRESC_LOG2)) u_presc (
        .clk(clk), .rst_n(rst_n), .slow_sel(slow_sel), .tick(tick)
    );

    tcap_counter #(.W(CNT_W), .MAXV(CNT_MAX)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .count(count), .wrap(wrap)
    );

    tcap_capture #(.W(CNT_W), .SYNC(SYNC_DEPTH)) u_cap (
        .clk(clk), .rst_n(rst_n), .pin(cap_pin), .count(count),
        .clr(cap_clr), .cap_val(cap_val), .cap_flag(cap_flag)
    );

    tcap_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wrap(wrap), .cap_val(cap_val), .cap_flag(cap_flag),
        .cap_clr(cap_clr), .slow_sel(slow_sel),
        .irq_tick(irq_tick), .irq_capture(irq_capture)
    );
endmodule

// File: tb/tick_capture_timer_bench.sv
module tick_capture_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       cap_pin = 1'b0;
    logic       irq_tick;
    logic       irq_capture;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 0;

    // Requirement-level model of the prescaler and counter.
    int m_presc = 0;
    int m_cnt = 0;
    bit m_slow = 0;

    always #2 clk = ~clk;

    tick_capture_timer u_tick_capture_timer (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cap_pin(cap_pin), .irq_tick(irq_tick), .irq_capture(irq_capture)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            cyc <= 0; m_presc <= 0; m_cnt <= 0; m_slow <= 0;
        end else begin
            cyc <= cyc + 1;
            if (m_presc >= (m_slow ? 63 : 31)) begin
                m_presc <= 0;
                m_cnt <= (m_cnt == 249) ? 0 : m_cnt + 1;
            end else begin
                m_presc <= m_presc + 1;
            end
            if (bus_wr && bus_addr == 2'd0) m_slow <= bus_wdata[2];
        end
    end

    // {addr, wr, wdata, expected read data}
    localparam logic [18:0] VEC [10] = '{
        {2'd0, 1'b1, 8'hFF, 8'h00},
        {2'd0, 1'b0, 8'h00, 8'h16},
        {2'd0, 1'b1, 8'h00, 8'h00},
        {2'd0, 1'b0, 8'h00, 8'h00},
        {2'd1, 1'b1, 8'hA5, 8'h00},
        {2'd1, 1'b0, 8'h00, 8'h00},
        {2'd2, 1'b1, 8'h5A, 8'h00},
        {2'd2, 1'b0, 8'h00, 8'h00},
        {2'd3, 1'b0, 8'h00, 8'h00},
        {2'd0, 1'b0, 8'h00, 8'h00}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic wait_cyc(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    // Toggle the pin to lvl; return the value the capture must hold (R7).
    task automatic pin_capture(input logic lvl, output int expv);
        int c;
        c = cyc;
        cap_pin = lvl;
        wait_cyc(c + 2);
        expv = m_cnt;
        check("R7 flag not yet set", irq_capture, 0);
        wait_cyc(c + 3);
        check("R7/R8 flag set after sync", irq_capture, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        int expv, expv2, t0, t1;
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 reset rdata", bus_rdata, 0);
        check("R10 reset irq_tick", irq_tick, 0);
        check("R10 reset irq_capture", irq_capture, 0);
        rst_n = 1'b1;
        bus_write(2'd0, 8'h02);          // tick enable
        // R2: first wrap on clock 8000
        wait_cyc(7999);
        check("R2 no flag before 8000", irq_tick, 0);
        @(negedge clk);
        check("R2/R4 flag at 8000", irq_tick, 1);
        bus_read(2'd0, d);
        check("R5 read shows flag", d & 8'h01, 1);
        check("R5 read clears flag", irq_tick, 0);
        // R5: wrap coincides with clearing read on clock 16000
        wait_cyc(15999);
        bus_read(2'd0, d);
        check("R5 coincident read data", d & 8'h01, 0);
        check("R5 set wins over clear", irq_tick, 1);
        bus_read(2'd0, d);
        check("R5 second read sees flag", d & 8'h01, 1);
        check("R5 second read clears", irq_tick, 0);
        // R6/R10: register table
        foreach (VEC[i]) begin
            if (VEC[i][16]) bus_write(VEC[i][18:17], VEC[i][15:8]);
            else begin
                bus_read(VEC[i][18:17], d);
                check($sformatf("R6/R10 table row %0d", i), d, VEC[i][7:0]);
            end
        end
        // R7/R8/R9: captures
        bus_write(2'd0, 8'h12);
        repeat (77) @(negedge clk);
        pin_capture(1'b1, expv);
        repeat (40) @(negedge clk);
        cap_pin = 1'b0;                  // edge while flag pending (R9)
        repeat (6) @(negedge clk);
        check("R9 flag still set", irq_capture, 1);
        bus_read(2'd1, d);
        check("R9 first capture kept", d, expv);
        check("R8 read clears capture flag", irq_capture, 0);
        repeat (5) @(negedge clk);
        check("R9 inhibited edge not replayed", irq_capture, 0);
        repeat (300) @(negedge clk);
        pin_capture(1'b1, expv2);
        bus_read(2'd1, d);
        check("R7 rising capture value", d, expv2);
        repeat (500) @(negedge clk);
        pin_capture(1'b0, expv2);
        bus_read(2'd1, d);
        check("R7 falling capture value", d, expv2);
        check("R1 counter advanced between captures", int'(expv2 != expv), 1);
        // R3: doubled period
        bus_write(2'd0, 8'h16);
        while (!irq_tick) @(negedge clk);
        bus_read(2'd0, d);
        while (!irq_tick) @(negedge clk);
        t0 = cyc;
        bus_read(2'd0, d);
        while (!irq_tick) @(negedge clk);
        t1 = cyc;
        check("R3 doubled wrap interval", t1 - t0, 16000);
        finish_run();
    end
endmodule